// File: doc/BRIEF.md
# External Interrupt Controller

This block gathers a parameterised number of external interrupt pins, up to 32, and turns them into one interrupt request for a processor. Each pin is first brought into the clock domain by a two-stage synchroniser. It can then be set to catch a rising or a falling transition, or to follow a high or low level. An event latches a per-line pending bit. The request output is raised while any pending line is also enabled.

Software reaches the block over a plain 32-bit register port: byte address, write strobe, write data and combinational read data. The enable mask has two addresses, one that sets bits and one that clears them. Pending bits are cleared by writing ones. The sense-select register returns zeros for pins that are not built, so a driver can write all ones, read the value back and count the lines. A diagnostic flag and a non-maskable enable flag are plain storage bits.

Top module: `xint_ctrl`

## Requirements
- R1: After reset every register reads zero and `irqOut` is low. The write-only offsets 0x00, 0x04 and 0x10 always read zero.
- R2: Writing ones to offset 0x00 sets the matching enable bits. Zero bits leave their enable bits unchanged. The enable mask reads back at offset 0x08.
- R3: Writing ones to offset 0x04 clears the matching enable bits. Zero bits leave their enable bits unchanged.
- R4: `irqOut` is high exactly when some line has both its pending bit and its enable bit set. A pending line that is not enabled does not raise it.
- R5: Pending bits read at offset 0x0C. Writing a 1 to a bit of offset 0x10 clears that pending bit, and a 0 leaves it alone. An edge-triggered pending bit stays set until it is cleared.
- R6: The sense register at offset 0x14 selects per line: 1 is level, 0 is edge. Only bits 0 to NUM_LINES-1 exist, so writing all ones reads back as 2^NUM_LINES-1.
- R7: The edge register at offset 0x18 selects per line: 1 is rising, 0 is falling. With sense and edge both 0, a falling transition sets the pending bit and a rising one does not.
- R8: The level register at offset 0x1C selects per line: 1 is active high, 0 is active low. In level mode the pending bit is held at 1 while the input is active, so a clear write has no effect until the input goes inactive. The bit then stays set until it is cleared.
- R9: A change at an input reaches its pending bit on the third rising clock edge after the change. It is not yet visible after the second edge.
- R10: A detected event sets the pending bit whether or not the line is enabled.
- R11: Offset 0x20 stores a diagnostic flag in bit 31. Offset 0x24 stores a non-maskable enable flag in bit 0. All other bits of these two registers read zero.
- R12: Writing ones to bits at or above NUM_LINES has no effect. Those bits read zero in the enable, pending, sense, edge and level registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extIn | input | NUM_LINES | External interrupt pins, asynchronous |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench samples pending bits one cycle before and one cycle at the point where a transition should appear. A synchroniser with a stage too many or too few therefore shows up as a wrong value in one of those two reads. It writes mixed one and zero patterns to the set, clear and pending-clear addresses. A design that loaded the raw word instead of acting only on the one bits would wipe or set unrelated lines. It sends a clear while a level line is still active, which a design that let the clear win would drop too early. It raises an event on a disabled line, which a design that gated capture with the mask would lose. It writes ones above the implemented width, which would show up in the line count read back from the sense register.

// File: rtl/xint_pkg.sv
package xint_pkg;

  localparam int ADDR_W = 8;

  // Byte offsets of the register file; software decodes these.
  localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PCLR  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EDGE  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_DIAG  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_NMCTL = 8'h24;

  localparam int DIAG_BIT = 31;
  localparam int NM_BIT   = 0;

  typedef enum logic [3:0] {
    RS_NONE, RS_MASK, RS_PEND, RS_SENSE, RS_EDGE, RS_LEVEL, RS_DIAG, RS_NMCTL
  } rdSel_e;

  // One-cycle write strobes from the decoder to the datapath.
  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic pendClr;
    logic senseWr;
    logic edgeWr;
    logic levelWr;
    logic diagWr;
    logic nmWr;
  } strobes_t;

endpackage

// File: rtl/xint_ctrl_dec.sv
module xint_ctrl_dec
  import xint_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobes_t          strb,
  output rdSel_e            rdSel
);

  always_comb begin
    strb = '0;
    if (busWrEn) begin
      case (busAddr)
        OFS_ENSET: strb.maskSet = 1'b1;
        OFS_ENCLR: strb.maskClr = 1'b1;
        OFS_PCLR:  strb.pendClr = 1'b1;
        OFS_SENSE: strb.senseWr = 1'b1;
        OFS_EDGE:  strb.edgeWr  = 1'b1;
        OFS_LEVEL: strb.levelWr = 1'b1;
        OFS_DIAG:  strb.diagWr  = 1'b1;
        OFS_NMCTL: strb.nmWr    = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

  always_comb begin
    case (busAddr)
      OFS_MASK:  rdSel = RS_MASK;
      OFS_PEND:  rdSel = RS_PEND;
      OFS_SENSE: rdSel = RS_SENSE;
      OFS_EDGE:  rdSel = RS_EDGE;
      OFS_LEVEL: rdSel = RS_LEVEL;
      OFS_DIAG:  rdSel = RS_DIAG;
      OFS_NMCTL: rdSel = RS_NMCTL;
      default:   rdSel = RS_NONE;
    endcase
  end

endmodule

// File: rtl/xint_ctrl_dp.sv
module xint_ctrl_dp
  import xint_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] extIn,
  input  strobes_t             strb,
  input  rdSel_e               rdSel,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic                 irqOut,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [NUM_LINES-1:0] maskVec
);

  typedef logic [NUM_LINES-1:0] lineVec_t;

  lineVec_t wrBits;
  lineVec_t sync1Q, syncQ, prevQ;
  lineVec_t maskQ, pendQ, senseQ, edgeQ, levelQ;
  lineVec_t evt;
  logic     diagQ, nmQ;

  // Only the implemented lines take part in any write.
  assign wrBits = busWrData[NUM_LINES-1:0];

  // Two-stage synchroniser plus one stage of history for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1Q <= '0;
      syncQ  <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= extIn;
      syncQ  <= sync1Q;
      prevQ  <= syncQ;
    end
  end

  // Per-line event: a level match in level mode, or the selected transition.
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic lvlActive, riseSeen, fallSeen;
    assign lvlActive = (syncQ[g] == levelQ[g]);
    assign riseSeen  =  syncQ[g] & ~prevQ[g];
    assign fallSeen  = ~syncQ[g] &  prevQ[g];
    assign evt[g]    = senseQ[g] ? lvlActive : (edgeQ[g] ? riseSeen : fallSeen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      pendQ  <= '0;
      senseQ <= '0;
      edgeQ  <= '0;
      levelQ <= '0;
      diagQ  <= 1'b0;
      nmQ    <= 1'b0;
    end else begin
      if (strb.maskSet)      maskQ <= maskQ | wrBits;
      else if (strb.maskClr) maskQ <= maskQ & ~wrBits;
      // An event in the same cycle as a clear wins, which also holds level lines.
      pendQ <= (strb.pendClr ? (pendQ & ~wrBits) : pendQ) | evt;
      if (strb.senseWr) senseQ <= wrBits;
      if (strb.edgeWr)  edgeQ  <= wrBits;
      if (strb.levelWr) levelQ <= wrBits;
      if (strb.diagWr)  diagQ  <= busWrData[DIAG_BIT];
      if (strb.nmWr)    nmQ    <= busWrData[NM_BIT];
    end
  end

  always_comb begin
    busRdData = '0;
    case (rdSel)
      RS_MASK:  busRdData[NUM_LINES-1:0] = maskQ;
      RS_PEND:  busRdData[NUM_LINES-1:0] = pendQ;
      RS_SENSE: busRdData[NUM_LINES-1:0] = senseQ;
      RS_EDGE:  busRdData[NUM_LINES-1:0] = edgeQ;
      RS_LEVEL: busRdData[NUM_LINES-1:0] = levelQ;
      RS_DIAG:  busRdData[DIAG_BIT]      = diagQ;
      RS_NMCTL: busRdData[NM_BIT]        = nmQ;
      default:  busRdData = '0;
    endcase
  end

  assign irqOut  = |(pendQ & maskQ);
  assign pendVec = pendQ;
  assign maskVec = maskQ;

endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int NUM_LINES = 8  // 1 to 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] extIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic                 irqOut
);

  strobes_t             strb;
  rdSel_e               rdSel;
  logic [NUM_LINES-1:0] pendVec;
  logic [NUM_LINES-1:0] maskVec;

  xint_ctrl_dec u_dec (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  xint_ctrl_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .extIn     (extIn),
    .strb      (strb),
    .rdSel     (rdSel),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .pendVec   (pendVec),
    .maskVec   (maskVec)
  );

endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
  import xint_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [31:0]          busWrData,
  input logic [31:0]          busRdData,
  input logic                 irqOut,
  input logic [NUM_LINES-1:0] pendVec,
  input logic [NUM_LINES-1:0] maskVec
);

  localparam logic [31:0] IMPL = (NUM_LINES >= 32) ? 32'hFFFF_FFFF
                                                   : ((32'd1 << NUM_LINES) - 32'd1);

  logic [NUM_LINES-1:0] wd, clrBits;
  logic                 vecRead;
  assign wd      = busWrData[NUM_LINES-1:0];
  assign clrBits = (busWrEn && busAddr == OFS_PCLR) ? wd : '0;
  assign vecRead = (busAddr == OFS_MASK) || (busAddr == OFS_PEND) || (busAddr == OFS_SENSE)
                || (busAddr == OFS_EDGE) || (busAddr == OFS_LEVEL);

  // R2: ones written to the set address are present in the mask next cycle.
  a_r2_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_ENSET) |=> ((maskVec & $past(wd)) == $past(wd)));

  // R3: ones written to the clear address are gone from the mask next cycle.
  a_r3_enable_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_ENCLR) |=> ((maskVec & $past(wd)) == '0));

  // R4: with nothing enabled the request stays low.
  a_r4_quiet_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> !irqOut);

  // R5: a pending bit only falls in the cycle after a clear write naming it.
  a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pendVec) & ~pendVec & ~$past(clrBits)) == '0));

  // R12: line-vector registers never show bits above the implemented width.
  a_r12_read_width: assert property (@(posedge clk) disable iff (!rstN)
    vecRead |-> ((busRdData & ~IMPL) == '0));

endmodule

bind xint_ctrl xint_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .irqOut    (irqOut),
  .pendVec   (pendVec),
  .maskVec   (maskVec)
);

// File: tb/xint_ctrl_tb.sv
module xint_ctrl_tb;
  import xint_pkg::*;

  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  extIn;
  logic [7:0]    busAddr;
  logic          busWrEn;
  logic [31:0]   busWrData;
  logic [31:0]   busRdData;
  logic          irqOut;

  always #5 clk = ~clk;

  xint_ctrl #(.NUM_LINES(N)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .extIn     (extIn),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

  typedef struct {
    logic        isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;

  // Driver side: each call starts at a falling edge and ends at the next one.
  task automatic expRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    busAddr = a;
    sbQ.push_back('{1'b0, e, tag});
    @(negedge clk);
  endtask

  task automatic expIrq(input logic e, input string tag);
    sbQ.push_back('{1'b1, {31'b0, e}, tag});
    @(negedge clk);
  endtask

  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    busAddr   = a;
    busWrData = d;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
    busWrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor side: compares shortly after each falling edge.
  always @(negedge clk) begin
    item_t       it;
    logic [31:0] act;
    #2;
    if (sbQ.size() > 0) begin
      it  = sbQ.pop_front();
      act = it.isIrq ? {31'b0, irqOut} : busRdData;
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    extIn     = '1;
    busAddr   = '0;
    busWrEn   = 1'b0;
    busWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: everything clear after reset
    for (int i = 0; i < 10; i++) expRead(8'(i * 4), 32'h0, "R1");
    expIrq(1'b0, "R1");

    // R6: sense register reveals the line count
    regWr(OFS_SENSE, 32'hFFFF_FFFF);
    expRead(OFS_SENSE, 32'h0000_00FF, "R6");
    regWr(OFS_SENSE, 32'h0);
    expRead(OFS_SENSE, 32'h0, "R6");

    // R2, R12: set mask bits, zeros and unimplemented bits have no effect
    regWr(OFS_ENSET, 32'h5);
    expRead(OFS_MASK, 32'h5, "R2");
    regWr(OFS_ENSET, 32'h2);
    expRead(OFS_MASK, 32'h7, "R2");
    regWr(OFS_ENSET, 32'hFFFF_FF00);
    expRead(OFS_MASK, 32'h7, "R12");

    // R3: clear mask bits
    regWr(OFS_ENCLR, 32'h1);
    expRead(OFS_MASK, 32'h6, "R3");
    regWr(OFS_ENCLR, 32'h0);
    expRead(OFS_MASK, 32'h6, "R3");

    // R9, R7: default falling edge on line 1, exact latency
    extIn[1] = 1'b0;
    idle(2);
    expRead(OFS_PEND, 32'h0, "R9");
    expRead(OFS_PEND, 32'h2, "R9");
    expIrq(1'b1, "R4");

    // R10: event on disabled line 0 still latches
    extIn[0] = 1'b0;
    idle(3);
    expRead(OFS_PEND, 32'h3, "R10");

    // R4, R5: clear the enabled line, masked pending keeps irq low
    regWr(OFS_PCLR, 32'h2);
    expRead(OFS_PEND, 32'h1, "R5");
    expIrq(1'b0, "R4");
    regWr(OFS_PCLR, 32'h0);
    expRead(OFS_PEND, 32'h1, "R5");
    regWr(OFS_ENSET, 32'h1);
    expIrq(1'b1, "R4");
    regWr(OFS_ENCLR, 32'h1);
    regWr(OFS_PCLR, 32'h1);
    expRead(OFS_PEND, 32'h0, "R5");
    expIrq(1'b0, "R4");

    // R7: rising edge on line 3, falling ignored
    regWr(OFS_EDGE, 32'h8);
    expRead(OFS_EDGE, 32'h8, "R7");
    extIn[3] = 1'b0;
    idle(4);
    expRead(OFS_PEND, 32'h0, "R7");
    extIn[3] = 1'b1;
    idle(3);
    expRead(OFS_PEND, 32'h8, "R7");
    regWr(OFS_PCLR, 32'h8);
    expRead(OFS_PEND, 32'h0, "R7");

    // R8: line 4 active high level, line 5 active low level
    regWr(OFS_LEVEL, 32'h10);
    regWr(OFS_SENSE, 32'h30);
    idle(1);
    expRead(OFS_PEND, 32'h10, "R8");
    regWr(OFS_PCLR, 32'h10);
    expRead(OFS_PEND, 32'h10, "R8");
    extIn[4] = 1'b0;
    idle(3);
    expRead(OFS_PEND, 32'h10, "R8");
    regWr(OFS_PCLR, 32'h10);
    expRead(OFS_PEND, 32'h0, "R8");
    extIn[5] = 1'b0;
    idle(3);
    expRead(OFS_PEND, 32'h20, "R8");
    extIn[5] = 1'b1;
    idle(3);
    regWr(OFS_PCLR, 32'h20);
    expRead(OFS_PEND, 32'h0, "R8");

    // R11: single-bit flag registers
    regWr(OFS_DIAG, 32'hFFFF_FFFF);
    expRead(OFS_DIAG, 32'h8000_0000, "R11");
    regWr(OFS_NMCTL, 32'hFFFF_FFFF);
    expRead(OFS_NMCTL, 32'h0000_0001, "R11");

    idle(2);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule